// File: doc/BRIEF.md
# Two-Phase Operand Selection Network

This block is the register-and-multiplexer fabric that sits around an execution unit's ALU. It stages operands from the register file, from the instruction unit and from a shared result bus into the left and right ALU inputs. It takes the ALU and field-unit results into a result pipeline and writes them back onto the result bus. It also stages store data towards an external data driver. The register file, the ALU and the field unit are outside this block. It only selects sources and holds values.

The two clock phases are modelled on a single clock by two enables, `ph_a` and `ph_b`. Each register belongs to one phase and has a fixed list of sources. A register loads only when its phase enable is high and exactly one bit of its select is set. A select with more than one bit set, or a request for both result-bus drivers at once, leaves the affected register unchanged and raises a sticky error flag. Every register reads the values its sources held before the clock edge, so a value moves one stage per load.

Top module: `opsel_net`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register and `err_o` to zero, so `lhs_o`, `rhs_o` and `rbus_o` read zero afterwards.
- R2: The registers lhs, rhs, fld, sd1, sd3 and res2 load only on an edge where `ph_a` is high. The registers imm, res1, sd2 and the result bus load only on an edge where `ph_b` is high. An all-zero select or load request leaves a register unchanged.
- R3: The lhs register selects with `sel_lhs` bit 0 = `rf_a`, bit 1 = res1 and bit 2 = result bus. The store register sd1 selects with `sel_sd1` bit 0 = `rf_b`, bit 1 = res1 and bit 2 = result bus.
- R4: The rhs register selects with `sel_rhs` bit 0 = `rf_b`, bit 1 = res1, bit 2 = result bus, bit 3 = imm and bit 4 = fld.
- R5: The res1 register selects with `sel_res1` bit 0 = `alu_res`, bit 1 = `fu_res` and bit 2 = the lhs register.
- R6: Each of these registers has a single source: imm loads `iu_in` on `ld_imm`, fld loads the result bus on `ld_fld`, sd2 loads sd1 on `ld_sd2`, and res2 loads res1 on `ld_res2`. The sd3 register selects with `sel_sd3` bit 0 = sd2 and bit 1 = result bus.
- R7: On a `ph_b` edge the result bus takes res2 when only `drv_res3` is high, and takes `ext_in` when only `drv_ext` is high. With neither driver requested it keeps its last value.
- R8: `ext_out` follows the inputs without a clock: it shows sd3 when `sel_ext` is 01, res1 when `sel_ext` is 10, and zero when `sel_ext` is 00 or 11.
- R9: Any of the following sets `err_o` at the next edge and leaves the affected register unchanged: a select with two or more bits set on its active phase, both result-bus drivers requested on a `ph_b` edge, or `sel_ext` equal to 11.
- R10: Once set, `err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_a | input | 1 | Phase A capture enable |
| ph_b | input | 1 | Phase B capture enable |
| rf_a | input | W | Register-file read port A |
| rf_b | input | W | Register-file read port B |
| iu_in | input | W | Instruction-unit value |
| alu_res | input | W | ALU result |
| fu_res | input | W | Field-unit result |
| ext_in | input | W | External data-in bus |
| sel_lhs | input | 3 | One-hot source select for lhs |
| sel_rhs | input | 5 | One-hot source select for rhs |
| sel_sd1 | input | 3 | One-hot source select for sd1 |
| sel_res1 | input | 3 | One-hot source select for res1 |
| sel_sd3 | input | 2 | One-hot source select for sd3 |
| sel_ext | input | 2 | One-hot source select for the external driver |
| ld_imm | input | 1 | Load request for imm |
| ld_fld | input | 1 | Load request for fld |
| ld_sd2 | input | 1 | Load request for sd2 |
| ld_res2 | input | 1 | Load request for res2 |
| drv_res3 | input | 1 | Drive the result bus from res2 |
| drv_ext | input | 1 | Drive the result bus from ext_in |
| lhs_o | output | W | Left ALU operand |
| rhs_o | output | W | Right ALU operand |
| rbus_o | output | W | Result bus |
| ext_out | output | W | External data driver |
| err_o | output | 1 | Sticky select-conflict flag |

## Verification
The bench builds the block at its default 32-bit width. It gives every source a distinct word, so a wrong select bit, a swapped bus or a load on the wrong phase shows up as a different value at an output. Values are followed through the store path (sd1, sd2, sd3) and the result path (res1, res2, result bus), one phase at a time. This reaches registers that have no port of their own. The error cases run from a clean reset, so the held value and the flag can each be checked against a known state.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
    // source counts per selectable register
    localparam int LHS_N = 3;
    localparam int RHS_N = 5;
    localparam int SD1_N = 3;
    localparam int RES1_N = 3;
    localparam int SD3_N = 2;
    localparam int EXT_N = 2;

    // select bit positions (decoded by the control logic that drives them)
    localparam int LHS_RF = 0, LHS_RES = 1, LHS_BUS = 2;
    localparam int RHS_RF = 0, RHS_RES = 1, RHS_BUS = 2, RHS_IMM = 3, RHS_FLD = 4;
    localparam int RES_ALU = 0, RES_FU = 1, RES_LHS = 2;
    localparam int SD3_PREV = 0, SD3_BUS = 1;
    localparam int EXT_SD3 = 0, EXT_RES = 1;
endpackage

// File: rtl/opsel_onehot_pick.sv
module opsel_onehot_pick #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout,
    output logic                hit,
    output logic                multi
);
    logic [W-1:0] acc;
    logic         seen;

    always_comb begin
        acc   = '0;
        seen  = 1'b0;
        multi = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                acc = acc | din[i];
                if (seen) multi = 1'b1;
                seen = 1'b1;
            end
        end
        hit  = seen && !multi;
        dout = multi ? '0 : acc;
    end
endmodule

// File: rtl/opsel_bus_arb.sv
module opsel_bus_arb #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic         drv_int,
    input  logic         drv_ext,
    input  logic [W-1:0] d_int,
    input  logic [W-1:0] d_ext,
    output logic         load,
    output logic [W-1:0] dout,
    output logic         clash
);
    always_comb begin
        load  = en && (drv_int ^ drv_ext);
        clash = en && drv_int && drv_ext;
        dout  = drv_int ? d_int : d_ext;
    end
endmodule

// File: rtl/opsel_net.sv
module opsel_net
    import opsel_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic [W-1:0]      rf_a,
    input  logic [W-1:0]      rf_b,
    input  logic [W-1:0]      iu_in,
    input  logic [W-1:0]      alu_res,
    input  logic [W-1:0]      fu_res,
    input  logic [W-1:0]      ext_in,
    input  logic [LHS_N-1:0]  sel_lhs,
    input  logic [RHS_N-1:0]  sel_rhs,
    input  logic [SD1_N-1:0]  sel_sd1,
    input  logic [RES1_N-1:0] sel_res1,
    input  logic [SD3_N-1:0]  sel_sd3,
    input  logic [EXT_N-1:0]  sel_ext,
    input  logic              ld_imm,
    input  logic              ld_fld,
    input  logic              ld_sd2,
    input  logic              ld_res2,
    input  logic              drv_res3,
    input  logic              drv_ext,
    output logic [W-1:0]      lhs_o,
    output logic [W-1:0]      rhs_o,
    output logic [W-1:0]      rbus_o,
    output logic [W-1:0]      ext_out,
    output logic              err_o
);
    typedef struct packed {
        logic [W-1:0] imm;
        logic [W-1:0] rhs;
        logic [W-1:0] fld;
        logic [W-1:0] lhs;
        logic [W-1:0] sd1;
        logic [W-1:0] res1;
        logic [W-1:0] sd2;
        logic [W-1:0] sd3;
        logic [W-1:0] res2;
        logic [W-1:0] rbus;
        logic         err;
    } net_state_t;

    net_state_t st_q, st_d;

    // source vectors, indexed by select bit
    logic [LHS_N-1:0][W-1:0]  lhs_src;
    logic [RHS_N-1:0][W-1:0]  rhs_src;
    logic [SD1_N-1:0][W-1:0]  sd1_src;
    logic [RES1_N-1:0][W-1:0] res1_src;
    logic [SD3_N-1:0][W-1:0]  sd3_src;
    logic [EXT_N-1:0][W-1:0]  ext_src;

    always_comb begin
        lhs_src[LHS_RF]   = rf_a;
        lhs_src[LHS_RES]  = st_q.res1;
        lhs_src[LHS_BUS]  = st_q.rbus;
        rhs_src[RHS_RF]   = rf_b;
        rhs_src[RHS_RES]  = st_q.res1;
        rhs_src[RHS_BUS]  = st_q.rbus;
        rhs_src[RHS_IMM]  = st_q.imm;
        rhs_src[RHS_FLD]  = st_q.fld;
        sd1_src[LHS_RF]   = rf_b;
        sd1_src[LHS_RES]  = st_q.res1;
        sd1_src[LHS_BUS]  = st_q.rbus;
        res1_src[RES_ALU] = alu_res;
        res1_src[RES_FU]  = fu_res;
        res1_src[RES_LHS] = st_q.lhs;
        sd3_src[SD3_PREV] = st_q.sd2;
        sd3_src[SD3_BUS]  = st_q.rbus;
        ext_src[EXT_SD3]  = st_q.sd3;
        ext_src[EXT_RES]  = st_q.res1;
    end

    logic [W-1:0] lhs_v, rhs_v, sd1_v, res1_v, sd3_v, ext_v, bus_v;
    logic lhs_hit, rhs_hit, sd1_hit, res1_hit, sd3_hit, ext_hit;
    logic lhs_multi, rhs_multi, sd1_multi, res1_multi, sd3_multi, ext_multi;
    logic bus_load, bus_clash;

    opsel_onehot_pick #(.W(W), .N(LHS_N)) u_pick_lhs (
        .sel(sel_lhs), .din(lhs_src), .dout(lhs_v), .hit(lhs_hit), .multi(lhs_multi));
    opsel_onehot_pick #(.W(W), .N(RHS_N)) u_pick_rhs (
        .sel(sel_rhs), .din(rhs_src), .dout(rhs_v), .hit(rhs_hit), .multi(rhs_multi));
    opsel_onehot_pick #(.W(W), .N(SD1_N)) u_pick_sd1 (
        .sel(sel_sd1), .din(sd1_src), .dout(sd1_v), .hit(sd1_hit), .multi(sd1_multi));
    opsel_onehot_pick #(.W(W), .N(RES1_N)) u_pick_res1 (
        .sel(sel_res1), .din(res1_src), .dout(res1_v), .hit(res1_hit), .multi(res1_multi));
    opsel_onehot_pick #(.W(W), .N(SD3_N)) u_pick_sd3 (
        .sel(sel_sd3), .din(sd3_src), .dout(sd3_v), .hit(sd3_hit), .multi(sd3_multi));
    opsel_onehot_pick #(.W(W), .N(EXT_N)) u_pick_ext (
        .sel(sel_ext), .din(ext_src), .dout(ext_v), .hit(ext_hit), .multi(ext_multi));

    opsel_bus_arb #(.W(W)) u_bus_arb (
        .en(ph_b), .drv_int(drv_res3), .drv_ext(drv_ext),
        .d_int(st_q.res2), .d_ext(ext_in),
        .load(bus_load), .dout(bus_v), .clash(bus_clash));

    logic err_a, err_b;

    always_comb begin
        st_d  = st_q;
        err_a = ph_a && (lhs_multi || rhs_multi || sd1_multi || sd3_multi);
        err_b = ph_b && res1_multi;

        // phase A captures
        if (ph_a) begin
            if (lhs_hit) st_d.lhs = lhs_v;
            if (rhs_hit) st_d.rhs = rhs_v;
            if (sd1_hit) st_d.sd1 = sd1_v;
            if (sd3_hit) st_d.sd3 = sd3_v;
            if (ld_fld)  st_d.fld = st_q.rbus;
            if (ld_res2) st_d.res2 = st_q.res1;
        end

        // phase B captures
        if (ph_b) begin
            if (ld_imm)   st_d.imm = iu_in;
            if (res1_hit) st_d.res1 = res1_v;
            if (ld_sd2)   st_d.sd2 = st_q.sd1;
        end
        if (bus_load) st_d.rbus = bus_v;

        if (err_a || err_b || bus_clash || ext_multi) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lhs_o   = st_q.lhs;
    assign rhs_o   = st_q.rhs;
    assign rbus_o  = st_q.rbus;
    assign ext_out = ext_hit ? ext_v : '0;
    assign err_o   = st_q.err;
endmodule

// File: rtl/opsel_net_chk.sv
module opsel_net_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         ph_a,
    input logic         ph_b,
    input logic [2:0]   sel_lhs,
    input logic [4:0]   sel_rhs,
    input logic [1:0]   sel_ext,
    input logic         drv_res3,
    input logic         drv_ext,
    input logic [W-1:0] lhs_o,
    input logic [W-1:0] rhs_o,
    input logic [W-1:0] rbus_o,
    input logic [W-1:0] ext_out,
    input logic         err_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (err_o == 1'b0 && lhs_o == '0 && rhs_o == '0 && rbus_o == '0));

    // R2
    lhs_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph_a || sel_lhs == 3'b000) |=> $stable(lhs_o));

    // R2
    rhs_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph_a || sel_rhs == 5'b00000) |=> $stable(rhs_o));

    // R7
    bus_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph_b || (!drv_res3 && !drv_ext)) |=> $stable(rbus_o));

    // R8
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_ext == 2'b00 || sel_ext == 2'b11) |-> ext_out == '0);

    // R9
    lhs_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_a && $countones(sel_lhs) > 1) |=> (err_o && $stable(lhs_o)));

    // R9
    bus_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_b && drv_res3 && drv_ext) |=> (err_o && $stable(rbus_o)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind opsel_net opsel_net_chk #(.W(W)) u_opsel_chk (.*);

// File: tb/opsel_net_test.sv
module opsel_net_test;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst, ph_a, ph_b;
    logic [W-1:0] rf_a, rf_b, iu_in, alu_res, fu_res, ext_in;
    logic [2:0] sel_lhs, sel_sd1, sel_res1;
    logic [4:0] sel_rhs;
    logic [1:0] sel_sd3, sel_ext;
    logic ld_imm, ld_fld, ld_sd2, ld_res2, drv_res3, drv_ext;
    logic [W-1:0] lhs_o, rhs_o, rbus_o, ext_out;
    logic err_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    opsel_net #(.W(W)) uut (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b),
        .rf_a(rf_a), .rf_b(rf_b), .iu_in(iu_in), .alu_res(alu_res),
        .fu_res(fu_res), .ext_in(ext_in),
        .sel_lhs(sel_lhs), .sel_rhs(sel_rhs), .sel_sd1(sel_sd1),
        .sel_res1(sel_res1), .sel_sd3(sel_sd3), .sel_ext(sel_ext),
        .ld_imm(ld_imm), .ld_fld(ld_fld), .ld_sd2(ld_sd2), .ld_res2(ld_res2),
        .drv_res3(drv_res3), .drv_ext(drv_ext),
        .lhs_o(lhs_o), .rhs_o(rhs_o), .rbus_o(rbus_o), .ext_out(ext_out),
        .err_o(err_o));

    localparam logic [W-1:0] VA = 32'hA1A1_0001;
    localparam logic [W-1:0] VB = 32'hB2B2_0002;
    localparam logic [W-1:0] VI = 32'hC3C3_0003;
    localparam logic [W-1:0] VL = 32'hD4D4_0004;
    localparam logic [W-1:0] VF = 32'hE5E5_0005;
    localparam logic [W-1:0] VE = 32'hF6F6_0006;
    localparam logic [W-1:0] VA2 = 32'h1357_0007;
    localparam logic [W-1:0] VR = 32'h2468_0008;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_ctl();
        ph_a = 1'b0; ph_b = 1'b0;
        sel_lhs = '0; sel_rhs = '0; sel_sd1 = '0; sel_res1 = '0;
        sel_sd3 = '0; sel_ext = '0;
        ld_imm = 1'b0; ld_fld = 1'b0; ld_sd2 = 1'b0; ld_res2 = 1'b0;
        drv_res3 = 1'b0; drv_ext = 1'b0;
    endtask

    // one edge, then settle away from it; controls return to idle
    task automatic tick();
        @(posedge clk);
        #1;
        idle_ctl();
        #1;
    endtask

    task automatic do_reset();
        idle_ctl();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 lhs", lhs_o, '0);
        check("R1 rhs", rhs_o, '0);
        check("R1 rbus", rbus_o, '0);
        check("R1 ext", ext_out, '0);
        check("R1 err", {31'd0, err_o}, '0);
    endtask

    task automatic t_phase();
        rf_a = VA;
        ph_b = 1'b1; sel_lhs = 3'b001; tick();
        check("R2 lhs on wrong phase", lhs_o, '0);
        ph_a = 1'b1; tick();
        check("R2 lhs zero select", lhs_o, '0);
        ph_a = 1'b1; sel_lhs = 3'b001; tick();
        check("R3 lhs from rf_a", lhs_o, VA);
    endtask

    task automatic t_bus_ext();
        ext_in = VE;
        ph_a = 1'b1; drv_ext = 1'b1; tick();
        check("R2 bus on wrong phase", rbus_o, '0);
        ph_b = 1'b1; drv_ext = 1'b1; tick();
        check("R7 bus from ext_in", rbus_o, VE);
        ph_b = 1'b1; tick();
        check("R7 bus holds undriven", rbus_o, VE);
        ph_a = 1'b1; sel_lhs = 3'b100; sel_rhs = 5'b00100; tick();
        check("R3 lhs from bus", lhs_o, VE);
        check("R4 rhs from bus", rhs_o, VE);
    endtask

    task automatic t_res();
        alu_res = VL; fu_res = VF;
        ph_b = 1'b1; sel_res1 = 3'b001; tick();
        sel_ext = 2'b10; #1;
        check("R5 res1 from alu, R8 ext res1", ext_out, VL);
        ph_b = 1'b1; sel_res1 = 3'b010; tick();
        sel_ext = 2'b10; #1;
        check("R5 res1 from fu", ext_out, VF);
        ph_a = 1'b1; sel_rhs = 5'b00010; tick();
        check("R4 rhs from res1", rhs_o, VF);
        rf_a = VA2;
        ph_a = 1'b1; sel_lhs = 3'b001; tick();
        ph_b = 1'b1; sel_res1 = 3'b100; tick();
        sel_ext = 2'b10; #1;
        check("R5 res1 from lhs", ext_out, VA2);
        ph_a = 1'b1; sel_lhs = 3'b010; alu_res = VR; tick();
        check("R3 lhs from res1", lhs_o, VA2);
        rf_b = VB;
        ph_a = 1'b1; sel_rhs = 5'b00001; tick();
        check("R4 rhs from rf_b", rhs_o, VB);
    endtask

    task automatic t_imm_fld();
        iu_in = VI;
        ph_b = 1'b1; ld_imm = 1'b1; tick();
        ph_a = 1'b1; sel_rhs = 5'b01000; tick();
        check("R6 imm to rhs (R4 bit 3)", rhs_o, VI);
        ph_a = 1'b1; ld_fld = 1'b1; tick();
        ph_a = 1'b1; sel_rhs = 5'b10000; tick();
        check("R6 fld to rhs (R4 bit 4)", rhs_o, VE);
    endtask

    task automatic t_store();
        rf_b = VB;
        ph_a = 1'b1; sel_sd1 = 3'b001; tick();
        ph_b = 1'b1; ld_sd2 = 1'b1; tick();
        ph_a = 1'b1; sel_sd3 = 2'b01; tick();
        sel_ext = 2'b01; #1;
        check("R3 R6 store path to ext (R8)", ext_out, VB);
        ph_a = 1'b1; sel_sd3 = 2'b10; tick();
        sel_ext = 2'b01; #1;
        check("R6 sd3 from bus", ext_out, VE);
        sel_ext = 2'b00; #1;
        check("R8 ext zero select", ext_out, '0);
    endtask

    task automatic t_result();
        alu_res = VR;
        ph_b = 1'b1; sel_res1 = 3'b001; tick();
        ph_a = 1'b1; ld_res2 = 1'b1; tick();
        ph_b = 1'b1; drv_res3 = 1'b1; tick();
        check("R7 bus from res2 (R6)", rbus_o, VR);
    endtask

    task automatic t_conflict();
        check("R10 no err before conflict", {31'd0, err_o}, '0);
        ph_a = 1'b1; sel_lhs = 3'b011; tick();
        check("R9 lhs holds on multi select", lhs_o, VA2);
        check("R9 err on multi select", {31'd0, err_o}, 32'd1);
        tick(); tick();
        check("R10 err sticky", {31'd0, err_o}, 32'd1);
        do_reset();
        check("R1 err cleared", {31'd0, err_o}, '0);
        ext_in = VE;
        ph_b = 1'b1; drv_ext = 1'b1; drv_res3 = 1'b1; tick();
        check("R9 bus holds on clash", rbus_o, '0);
        check("R9 err on bus clash", {31'd0, err_o}, 32'd1);
        do_reset();
        sel_ext = 2'b11; #1;
        check("R8 ext zero on multi", ext_out, '0);
        sel_ext = 2'b11; tick();
        check("R9 err on ext multi", {31'd0, err_o}, 32'd1);
    endtask

    initial begin
        rst = 1'b1;
        rf_a = '0; rf_b = '0; iu_in = '0; alu_res = '0; fu_res = '0; ext_in = '0;
        idle_ctl();
        t_reset();
        t_phase();
        t_bus_ext();
        t_res();
        t_imm_fld();
        t_store();
        t_result();
        t_conflict();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule